// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer

This block turns three digitized supply comparator flags into the reset, interrupt and enable controls of a battery-backed processor. The three flags report that the main supply has fallen below a power-fail warning level, below the minimum operating level, or below the backup cell voltage. The analog comparators, the reference and the supply switch sit outside the block. Every flag is synchronized here before it is used.

A fall below the warning level raises a latched interrupt request while the processor keeps running. A fall below the minimum level holds the processor in reset. It also blocks the external memory enables and pulls a shared open-drain reset status line low. That status line is also read back, so another device that pulls it low resets this one as well. An active-high external reset pin also forces reset. When the supply comes back, the internal reset and the enable block are held for a fixed power-on delay, counted in clock periods. The fall below the backup level drives an active-low battery-active flag.

Top module: `supply_rst_seq`

## Requirements
- R1: Each asynchronous input (the three flags, the external reset and the status line) passes through two synchronizer flops, so its effect on a registered output appears on the third rising clock edge after the input changes, and not on the second.
- R2: While the below-minimum flag (1 = below) is set, cpu_rst_o, ce_inhibit_o and rst_line_pull_o are all 1.
- R3: When the status line input reads 0 while the supply is good, cpu_rst_o is 1, and rst_line_pull_o and ce_inhibit_o stay 0.
- R4: While ext_rst_i is 1, cpu_rst_o is 1. When ext_rst_i is released, cpu_rst_o returns to 0 on the third edge, with no power-on delay.
- R5: When the below-minimum flag clears, rst_line_pull_o drops on the third edge. cpu_rst_o and ce_inhibit_o stay 1 through edge POR_CYCLES+2 and fall on edge POR_CYCLES+3. The default for POR_CYCLES is 21504.
- R6: After the synchronous reset rst is released, cpu_rst_o and ce_inhibit_o stay 1 through edge POR_CYCLES and fall on edge POR_CYCLES+1.
- R7: bat_active_n_o is 0 while the below-battery flag (1 = below) is set, and 1 otherwise.
- R8: A 0-to-1 change of the synchronized below-warning flag while warn_ie_i is 1 sets warn_irq_o. The request stays set while the flag stays high.
- R9: No request is raised when warn_ie_i is 0 at the crossing. None is raised when the supply recovers above the warning level. None is raised again while the flag stays below.
- R10: warn_ack_i clears warn_irq_o on the next edge. A set request is also cleared while cpu_rst_o is 1.
- R11: While rst is held: cpu_rst_o=1, ce_inhibit_o=1, rst_line_pull_o=0, bat_active_n_o=1, warn_irq_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| below_warn_i | input | 1 | Async comparator: supply below warning level |
| below_min_i | input | 1 | Async comparator: supply below minimum operating level |
| below_bat_i | input | 1 | Async comparator: supply below backup cell |
| ext_rst_i | input | 1 | Async external reset pin, active high |
| rst_line_i | input | 1 | Sensed level of the open-drain reset status line, 0 = asserted |
| warn_ie_i | input | 1 | Warning interrupt enable |
| warn_ack_i | input | 1 | Warning interrupt acknowledge (one-cycle pulse) |
| warn_irq_o | output | 1 | Latched warning interrupt request |
| cpu_rst_o | output | 1 | Internal processor reset |
| ce_inhibit_o | output | 1 | Forces memory chip enables and write strobe inactive |
| rst_line_pull_o | output | 1 | 1 = pull the reset status line low |
| bat_active_n_o | output | 1 | 0 = running from backup cell |

## Verification
The hardest case to reach is the end of the power-on hold after a dip below the minimum level. The delay runs more than twenty thousand cycles. While it runs, the status line is still settling from this block's own pull, so two reset causes overlap near the start. The bench connects the pull output back to the line input through a wired-AND model. It then drives one full dip and samples the exact edges POR_CYCLES+2 and POR_CYCLES+3 after release. A second hard case is an interrupt request that is already latched when a reset begins. The bench reaches it by raising the warning and then asserting the external reset.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;
  typedef struct packed {
    logic warn;
    logic min;
    logic bat;
    logic ext;
    logic line_n;
  } supply_flags_t;

  localparam int FLAG_BITS = $bits(supply_flags_t);
  localparam supply_flags_t FLAGS_IDLE = '{warn: 1'b0, min: 1'b0, bat: 1'b0,
                                           ext: 1'b0, line_n: 1'b1};
endpackage

// File: rtl/supply_sync_bank.sv
module supply_sync_bank #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= INIT;
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/supply_por_timer.sv
module supply_por_timer #(
  parameter int POR_CYCLES = 21504
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic busy
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/supply_warn_irq.sv
module supply_warn_irq (
  input  logic clk,
  input  logic rst,
  input  logic below_warn,
  input  logic enable,
  input  logic ack,
  input  logic clear,
  output logic irq
);
  logic prev_q;
  logic crossing;

  assign crossing = below_warn && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      prev_q <= below_warn;
      if (clear)                   irq <= 1'b0;
      else if (crossing && enable) irq <= 1'b1;
      else if (ack)                irq <= 1'b0;
    end
  end
endmodule

// File: rtl/supply_rst_seq.sv
module supply_rst_seq
  import supply_rst_pkg::*;
#(
  parameter int POR_CYCLES  = 21504,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic below_warn_i,
  input  logic below_min_i,
  input  logic below_bat_i,
  input  logic ext_rst_i,
  input  logic rst_line_i,
  input  logic warn_ie_i,
  input  logic warn_ack_i,
  output logic warn_irq_o,
  output logic cpu_rst_o,
  output logic ce_inhibit_o,
  output logic rst_line_pull_o,
  output logic bat_active_n_o
);
  supply_flags_t raw_flags;
  supply_flags_t sync_flags;
  logic          por_busy;
  logic          rst_cause;

  assign raw_flags = '{warn: below_warn_i, min: below_min_i, bat: below_bat_i,
                       ext: ext_rst_i, line_n: rst_line_i};

  supply_sync_bank #(
    .WIDTH (FLAG_BITS),
    .STAGES(SYNC_STAGES),
    .INIT  (FLAGS_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_flags),
    .q  (sync_flags)
  );

  supply_por_timer #(
    .POR_CYCLES(POR_CYCLES)
  ) u_por (
    .clk (clk),
    .rst (rst),
    .hold(sync_flags.min),
    .busy(por_busy)
  );

  supply_warn_irq u_warn (
    .clk       (clk),
    .rst       (rst),
    .below_warn(sync_flags.warn),
    .enable    (warn_ie_i),
    .ack       (warn_ack_i),
    .clear     (cpu_rst_o),
    .irq       (warn_irq_o)
  );

  assign rst_cause = sync_flags.min || por_busy || sync_flags.ext || !sync_flags.line_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rst_o       <= 1'b1;
      ce_inhibit_o    <= 1'b1;
      rst_line_pull_o <= 1'b0;
      bat_active_n_o  <= 1'b1;
    end else begin
      cpu_rst_o       <= rst_cause;
      ce_inhibit_o    <= sync_flags.min || por_busy;
      rst_line_pull_o <= sync_flags.min;
      bat_active_n_o  <= !sync_flags.bat;
    end
  end
endmodule

// File: rtl/supply_rst_checker.sv
module supply_rst_checker (
  input logic clk,
  input logic rst,
  input logic warn_ie_i,
  input logic warn_ack_i,
  input logic warn_irq_o,
  input logic cpu_rst_o,
  input logic ce_inhibit_o,
  input logic rst_line_pull_o
);
  AST_PULL_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
    rst_line_pull_o |-> (cpu_rst_o && ce_inhibit_o)); // R2

  AST_INHIBIT_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
    ce_inhibit_o |-> cpu_rst_o); // R5

  AST_POR_OUTLASTS_PULL: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_line_pull_o) |-> (cpu_rst_o && ce_inhibit_o)); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_irq_o) |-> $past(warn_ie_i)); // R9

  AST_IRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(warn_irq_o) |-> ($past(warn_ack_i) || $past(cpu_rst_o))); // R10

  AST_RST_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_o |=> !warn_irq_o); // R10
endmodule

bind supply_rst_seq supply_rst_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .warn_ie_i      (warn_ie_i),
  .warn_ack_i     (warn_ack_i),
  .warn_irq_o     (warn_irq_o),
  .cpu_rst_o      (cpu_rst_o),
  .ce_inhibit_o   (ce_inhibit_o),
  .rst_line_pull_o(rst_line_pull_o)
);

// File: tb/tb_supply_rst_seq.sv
`timescale 1ns/1ps
module tb_supply_rst_seq;
  localparam int POR = 21504;
  localparam int WDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below_warn = 1'b0, below_min = 1'b0, below_bat = 1'b0, ext_rst = 1'b0;
  logic other_pull = 1'b0;
  logic warn_ie = 1'b0, warn_ack = 1'b0;
  logic warn_irq, cpu_rst, ce_inhibit, line_pull, bat_n;
  logic line_level;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign line_level = ~(line_pull | other_pull);

  supply_rst_seq dut (
    .clk(clk), .rst(rst),
    .below_warn_i(below_warn), .below_min_i(below_min), .below_bat_i(below_bat),
    .ext_rst_i(ext_rst), .rst_line_i(line_level),
    .warn_ie_i(warn_ie), .warn_ack_i(warn_ack),
    .warn_irq_o(warn_irq), .cpu_rst_o(cpu_rst), .ce_inhibit_o(ce_inhibit),
    .rst_line_pull_o(line_pull), .bat_active_n_o(bat_n)
  );

  // row: {bat, ext, other_pull, exp cpu_rst, exp bat_n}
  localparam logic [4:0] TABLE [6] = '{
    5'b000_0_1, 5'b100_0_0, 5'b010_1_1, 5'b001_1_1, 5'b111_1_0, 5'b000_0_1
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R11 cpu_rst", cpu_rst, 1'b1);
    chk("R11 inhibit", ce_inhibit, 1'b1);
    chk("R11 pull", line_pull, 1'b0);
    chk("R11 bat_n", bat_n, 1'b1);
    chk("R11 irq", warn_irq, 1'b0);
    rst = 1'b0;
    tick(POR);
    chk("R6 still held", cpu_rst, 1'b1);
    chk("R6 inhibit held", ce_inhibit, 1'b1);
    tick(1);
    chk("R6 released", cpu_rst, 1'b0);
    chk("R6 inhibit released", ce_inhibit, 1'b0);

    for (int i = 0; i < 6; i++) begin
      {below_bat, ext_rst, other_pull} = TABLE[i][4:2];
      tick(4);
      chk($sformatf("R3/R4 row%0d cpu_rst", i), cpu_rst, TABLE[i][1]);
      chk($sformatf("R7 row%0d bat_n", i), bat_n, TABLE[i][0]);
      chk($sformatf("R3 row%0d no pull", i), line_pull, 1'b0);
      chk($sformatf("R3 row%0d no inhibit", i), ce_inhibit, 1'b0);
    end

    ext_rst = 1'b1;
    tick(2);
    chk("R1 ext latency", cpu_rst, 1'b0);
    tick(1);
    chk("R4 ext asserts", cpu_rst, 1'b1);
    ext_rst = 1'b0;
    tick(2);
    chk("R1 ext release latency", cpu_rst, 1'b1);
    tick(1);
    chk("R4 no delay on release", cpu_rst, 1'b0);

    warn_ie = 1'b1;
    below_warn = 1'b1;
    tick(2);
    chk("R1 warn latency", warn_irq, 1'b0);
    tick(1);
    chk("R8 irq set", warn_irq, 1'b1);
    tick(5);
    chk("R8 irq held", warn_irq, 1'b1);
    warn_ack = 1'b1;
    tick(1);
    warn_ack = 1'b0;
    chk("R10 ack clears", warn_irq, 1'b0);
    tick(5);
    chk("R9 no re-raise", warn_irq, 1'b0);
    below_warn = 1'b0;
    tick(5);
    chk("R9 no irq on recovery", warn_irq, 1'b0);
    warn_ie = 1'b0;
    below_warn = 1'b1;
    tick(5);
    chk("R9 disabled crossing", warn_irq, 1'b0);
    below_warn = 1'b0;
    tick(4);
    warn_ie = 1'b1;
    below_warn = 1'b1;
    tick(3);
    chk("R8 irq set again", warn_irq, 1'b1);
    ext_rst = 1'b1;
    tick(4);
    chk("R10 reset clears irq", warn_irq, 1'b0);
    ext_rst = 1'b0;
    below_warn = 1'b0;
    tick(4);

    below_min = 1'b1;
    tick(2);
    chk("R1 min latency", line_pull, 1'b0);
    tick(1);
    chk("R2 pull", line_pull, 1'b1);
    chk("R2 cpu_rst", cpu_rst, 1'b1);
    chk("R2 inhibit", ce_inhibit, 1'b1);
    tick(3);
    below_min = 1'b0;
    tick(3);
    chk("R5 pull released", line_pull, 1'b0);
    tick(POR - 1);
    chk("R5 cpu_rst held", cpu_rst, 1'b1);
    chk("R5 inhibit held", ce_inhibit, 1'b1);
    tick(1);
    chk("R5 cpu_rst released", cpu_rst, 1'b0);
    chk("R5 inhibit released", ce_inhibit, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule